// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one DMA channel. In descriptor mode it reads a four-word descriptor from memory. The words are, in order: next-descriptor pointer, source address, target address and command word. It then moves the programmed number of bytes from the source to the target. Data moves in bursts. Each burst is first read into an internal 32-byte buffer and then written back out. When a descriptor runs out, the channel either stops or follows the next pointer and loads the next descriptor. A direct mode takes the source, target and command from configuration inputs instead of fetching them from memory.

All traffic goes through one memory port. The port uses a valid/ready handshake, allows one outstanding access, and returns read data in the accepting cycle. A peripheral request input paces flow-controlled transfers. When that request drops after a burst, the channel can flag end-of-receive and then stop or jump to a new descriptor. Start, end, stop and end-of-receive are reported as single-cycle event pulses. The remaining length and the current addresses are visible on status outputs.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset `run_o` is low, `mem_valid_o` is low and all four event outputs are low. With `run_o` low, no memory access is issued.
- R2: A descriptor fetch is four 4-byte reads (`mem_size_o`=2) at the pointer with bits 3:0 forced to zero, at offsets 0, 4, 8 and 12. The four words load next pointer, source, target and command, in that order.
- R3: If pointer bit 1 is set and `cmp_status_i` is high when the fetch starts, the fetch base is the aligned pointer plus 32.
- R4: When the command word is loaded, command bit 29 clears bits 1:0 of the loaded source address and command bit 28 clears bits 1:0 of the loaded target address.
- R5: `ev_start_o` pulses for one cycle, one cycle after the command word is accepted, exactly when command bit 22 is set. It never pulses in direct mode.
- R6: Command bits 15:14 select the element width: codes 2 and 3 give 2 and 4 bytes, and any other code gives 1 byte (`mem_size_o` 0, 1, 2 for 1, 2, 4 bytes). Bits 17:16 select the burst size as 4 shifted left by the code. Each burst covers min(remaining, burst size) bytes: all its element reads come first, then all its element writes, in the same order. The source advances by the width per element when bit 31 is set and the target does so when bit 30 is set; otherwise that address stays fixed. Element data sits in the low bytes of the data buses.
- R7: `cur_len_o` (command bits 12:0) drops by the burst size when the last write of a burst is accepted.
- R8: When the remaining length is zero, `ev_end_o` pulses if command bit 21 is set. The channel then stops if direct mode is active, if bit 0 of the next pointer is set, or if `cfg_eor_stop_i` is high: `ev_stop_o` pulses and `run_o` falls in that same cycle. Otherwise it fetches the descriptor at the next pointer and carries on.
- R9: While command bit 29 or bit 28 is set and `periph_req_i` is low, no burst is started and the length does not change.
- R10: After a burst that leaves a non-zero length, with flow control on and `periph_req_i` low, `ev_eor_o` pulses. The channel then stops if `cfg_eor_stop_i` is high, else fetches the next descriptor if `cfg_eor_jump_i` is high in descriptor mode, else waits for the request.
- R11: A `start_i` pulse with `cfg_nofetch_i` high loads source, target and command from the configuration inputs and starts the transfer with no descriptor reads.
- R12: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that starts the channel while it is idle |
| cfg_nofetch_i | input | 1 | Direct mode: take the transfer from the configuration inputs |
| cfg_desc_ptr_i | input | 32 | First descriptor pointer |
| cfg_src_i | input | 32 | Source address in direct mode |
| cfg_dst_i | input | 32 | Target address in direct mode |
| cfg_cmd_i | input | 32 | Command word in direct mode |
| cfg_eor_stop_i | input | 1 | Stop on end-of-receive and at the end of a descriptor |
| cfg_eor_jump_i | input | 1 | Fetch the next descriptor on end-of-receive |
| cmp_status_i | input | 1 | Compare status used to select the branch descriptor |
| periph_req_i | input | 1 | Peripheral request for flow-controlled transfers |
| mem_valid_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata_o | output | 32 | Write data, element in the low bytes |
| mem_ready_i | input | 1 | Access accepted at this clock edge |
| mem_rdata_i | input | 32 | Read data, valid in the accepting cycle |
| run_o | output | 1 | Channel is active |
| ev_start_o | output | 1 | Start event pulse |
| ev_end_o | output | 1 | End event pulse |
| ev_stop_o | output | 1 | Stop event pulse |
| ev_eor_o | output | 1 | End-of-receive event pulse |
| cur_len_o | output | 13 | Remaining byte count |
| cur_src_o | output | 32 | Current source address |
| cur_dst_o | output | 32 | Current target address |

## Verification
Every memory access is due in the cycle its handshake completes. The bench compares it, from a queue of expected accesses, at the falling edge just before the accepting rising edge, which is where the address, size and write data are stable. Event pulses are registered and appear the cycle after the deciding step, so they are counted at every falling edge and the counts are compared once `run_o` has fallen. The length and address outputs are read only after the channel has come to rest. During a flow-control hold, the bench waits a fixed 30 cycles and then confirms that exactly the expected number of accesses is still pending.

// File: rtl/cde_pkg.sv
package cde_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ARB, ST_READ, ST_WRITE, ST_POST
  } cde_state_e;

  localparam int WORD_W      = 32;
  localparam int CMD_SRC_INC = 31;
  localparam int CMD_DST_INC = 30;
  localparam int CMD_FLOW_S  = 29;
  localparam int CMD_FLOW_T  = 28;
  localparam int CMD_START_E = 22;
  localparam int CMD_END_E   = 21;

  // Fetch base: 16-byte aligned, +32 when the branch bit meets compare status.
  function automatic logic [WORD_W-1:0] fetch_base(input logic [WORD_W-1:0] ptr,
                                                   input logic cmp);
    logic [WORD_W-1:0] base;
    base = {ptr[WORD_W-1:4], 4'b0000};
    if (ptr[1] && cmp) base = base + WORD_W'(32);
    return base;
  endfunction
endpackage

// File: rtl/cde_cmd_decode.sv
module cde_cmd_decode #(
  parameter int LEN_W = 13,
  parameter int CW    = 6
) (
  input  logic [31:0]      cmd_i,
  output logic [LEN_W-1:0] len_o,
  output logic [2:0]       wbytes_o,
  output logic [1:0]       wcode_o,
  output logic [CW-1:0]    bsize_o,
  output logic             src_inc_o,
  output logic             dst_inc_o,
  output logic             flow_o,
  output logic             start_ie_o,
  output logic             end_ie_o
);
  import cde_pkg::*;

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_i[27:23], cmd_i[20:18], cmd_i[13]};

  assign len_o = cmd_i[LEN_W-1:0];

  always_comb begin
    unique case (cmd_i[15:14])
      2'd2:    begin wbytes_o = 3'd2; wcode_o = 2'd1; end
      2'd3:    begin wbytes_o = 3'd4; wcode_o = 2'd2; end
      default: begin wbytes_o = 3'd1; wcode_o = 2'd0; end
    endcase
  end

  assign bsize_o    = CW'(4) << cmd_i[17:16];
  assign src_inc_o  = cmd_i[CMD_SRC_INC];
  assign dst_inc_o  = cmd_i[CMD_DST_INC];
  assign flow_o     = cmd_i[CMD_FLOW_S] | cmd_i[CMD_FLOW_T];
  assign start_ie_o = cmd_i[CMD_START_E];
  assign end_ie_o   = cmd_i[CMD_END_E];
endmodule

// File: rtl/cde_burst_buf.sv
module cde_burst_buf #(
  parameter int BYTES = 32,
  localparam int IW   = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [2:0]    wr_bytes_i,
  input  logic [31:0]   wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [2:0]    rd_bytes_i,
  output logic [31:0]   rd_data_o
);
  logic [8*BYTES-1:0] flat;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] q;
    logic       sel;
    logic [1:0] lane;
    assign sel  = wr_en_i && (b >= int'(wr_idx_i)) &&
                  (b < int'(wr_idx_i) + int'(wr_bytes_i));
    assign lane = 2'(b - int'(wr_idx_i));
    always_ff @(posedge clk_i) begin
      if (sel) q <= wr_data_i[8*lane +: 8];
    end
    assign flat[8*b +: 8] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(rd_bytes_i) && (int'(rd_idx_i) + k) < BYTES)
        rd_data_o[8*k +: 8] = flat[8*(int'(rd_idx_i) + k) +: 8];
    end
  end

  // An element never runs past the end of the buffer (R6).
  assert_buf_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_idx_i) + int'(wr_bytes_i) <= BYTES));
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine #(
  parameter int BUF_BYTES = 32,
  parameter int LEN_W     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cfg_nofetch_i,
  input  logic [31:0]      cfg_desc_ptr_i,
  input  logic [31:0]      cfg_src_i,
  input  logic [31:0]      cfg_dst_i,
  input  logic [31:0]      cfg_cmd_i,
  input  logic             cfg_eor_stop_i,
  input  logic             cfg_eor_jump_i,
  input  logic             cmp_status_i,
  input  logic             periph_req_i,
  output logic             mem_valid_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [1:0]       mem_size_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             run_o,
  output logic             ev_start_o,
  output logic             ev_end_o,
  output logic             ev_stop_o,
  output logic             ev_eor_o,
  output logic [LEN_W-1:0] cur_len_o,
  output logic [31:0]      cur_src_o,
  output logic [31:0]      cur_dst_o
);
  import cde_pkg::*;

  localparam int IW = $clog2(BUF_BYTES);
  localparam int CW = IW + 1;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  cde_state_e  state_q, state_d;
  logic        run_q, run_d;
  logic        ev_start_q, ev_start_d, ev_end_q, ev_end_d;
  logic        ev_stop_q, ev_stop_d, ev_eor_q, ev_eor_d;
  logic [31:0] next_q, next_d, src_q, src_d, dst_q, dst_d, cmd_q, cmd_d;
  logic [31:0] fbase_q, fbase_d;
  logic [1:0]  idx_q, idx_d;
  logic [CW-1:0] cnt_q, cnt_d, bsz_q, bsz_d;
  logic        nofetch_q, nofetch_d;

  logic [LEN_W-1:0] len;
  logic [2:0]       wbytes;
  logic [1:0]       wcode;
  logic [CW-1:0]    bsize;
  logic             src_inc, dst_inc, flow, start_ie, end_ie;

  cde_cmd_decode #(.LEN_W(LEN_W), .CW(CW)) u_dec (
    .cmd_i(cmd_q), .len_o(len), .wbytes_o(wbytes), .wcode_o(wcode),
    .bsize_o(bsize), .src_inc_o(src_inc), .dst_inc_o(dst_inc),
    .flow_o(flow), .start_ie_o(start_ie), .end_ie_o(end_ie)
  );

  logic          buf_wr;
  logic [31:0]   buf_rd;
  logic [CW-1:0] cnt_step;
  logic          burst_last;
  logic [31:0]   src_step, dst_step;

  assign cnt_step   = cnt_q + CW'(wbytes);
  assign burst_last = (cnt_step >= bsz_q);
  assign src_step   = src_inc ? 32'(wbytes) : 32'd0;
  assign dst_step   = dst_inc ? 32'(wbytes) : 32'd0;

  cde_burst_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_n),
    .wr_en_i(buf_wr), .wr_idx_i(cnt_q[IW-1:0]), .wr_bytes_i(wbytes),
    .wr_data_i(mem_rdata_i),
    .rd_idx_i(cnt_q[IW-1:0]), .rd_bytes_i(wbytes), .rd_data_o(buf_rd)
  );

  // Next-state logic
  logic        launch, halt;
  logic [31:0] launch_ptr;
  always_comb begin
    state_d = state_q;  run_d = run_q;
    next_d = next_q;    src_d = src_q;   dst_d = dst_q;  cmd_d = cmd_q;
    fbase_d = fbase_q;  idx_d = idx_q;   cnt_d = cnt_q;  bsz_d = bsz_q;
    nofetch_d = nofetch_q;
    ev_start_d = 1'b0; ev_end_d = 1'b0; ev_stop_d = 1'b0; ev_eor_d = 1'b0;
    buf_wr = 1'b0; launch = 1'b0; halt = 1'b0; launch_ptr = next_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          run_d     = 1'b1;
          nofetch_d = cfg_nofetch_i;
          next_d    = cfg_desc_ptr_i;
          if (cfg_nofetch_i) begin
            src_d = cfg_src_i; dst_d = cfg_dst_i; cmd_d = cfg_cmd_i;
            state_d = ST_ARB;
          end else begin
            launch = 1'b1; launch_ptr = cfg_desc_ptr_i;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ready_i) begin
          idx_d = idx_q + 2'd1;
          unique case (idx_q)
            2'd0: next_d = mem_rdata_i;
            2'd1: src_d  = mem_rdata_i;
            2'd2: dst_d  = mem_rdata_i;
            default: begin
              cmd_d = mem_rdata_i;
              if (mem_rdata_i[CMD_FLOW_S]) src_d = {src_q[31:2], 2'b00};
              if (mem_rdata_i[CMD_FLOW_T]) dst_d = {dst_q[31:2], 2'b00};
              ev_start_d = mem_rdata_i[CMD_START_E];
              state_d = ST_ARB;
            end
          endcase
        end
      end
      ST_ARB: begin
        if (len == '0) begin
          state_d = ST_POST;
        end else if (!(flow && !periph_req_i)) begin
          bsz_d   = (len < LEN_W'(bsize)) ? CW'(len) : bsize;
          cnt_d   = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ready_i) begin
          buf_wr = 1'b1;
          src_d  = src_q + src_step;
          cnt_d  = cnt_step;
          if (burst_last) begin
            cnt_d = '0; state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ready_i) begin
          dst_d = dst_q + dst_step;
          cnt_d = cnt_step;
          if (burst_last) begin
            cmd_d[LEN_W-1:0] = len - LEN_W'(bsz_q);
            state_d = ST_POST;
          end
        end
      end
      ST_POST: begin
        if (len == '0) begin
          ev_end_d = end_ie;
          if (nofetch_q || next_q[0] || cfg_eor_stop_i) halt = 1'b1;
          else launch = 1'b1;
        end else if (flow && !periph_req_i) begin
          ev_eor_d = 1'b1;
          if (cfg_eor_stop_i)                     halt = 1'b1;
          else if (cfg_eor_jump_i && !nofetch_q)  launch = 1'b1;
          else                                    state_d = ST_ARB;
        end else begin
          state_d = ST_ARB;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (launch) begin
      fbase_d = fetch_base(launch_ptr, cmp_status_i);
      idx_d   = 2'd0;
      state_d = ST_FETCH;
    end
    if (halt) begin
      ev_stop_d = 1'b1; run_d = 1'b0; state_d = ST_IDLE;
    end
  end

  // Control registers (reset)
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; run_q <= 1'b0;
      ev_start_q <= 1'b0; ev_end_q <= 1'b0; ev_stop_q <= 1'b0; ev_eor_q <= 1'b0;
    end else begin
      state_q <= state_d; run_q <= run_d;
      ev_start_q <= ev_start_d; ev_end_q <= ev_end_d;
      ev_stop_q <= ev_stop_d;   ev_eor_q <= ev_eor_d;
    end
  end

  // Datapath registers (no reset, clock enable)
  logic dp_en;
  assign dp_en = (state_q != ST_IDLE) || start_i;
  always_ff @(posedge clk_i) begin
    if (dp_en) begin
      next_q <= next_d; src_q <= src_d; dst_q <= dst_d; cmd_q <= cmd_d;
      fbase_q <= fbase_d; idx_q <= idx_d; cnt_q <= cnt_d; bsz_q <= bsz_d;
      nofetch_q <= nofetch_d;
    end
  end

  // Memory port
  always_comb begin
    mem_valid_o = 1'b0; mem_we_o = 1'b0; mem_size_o = wcode;
    mem_addr_o  = src_q;
    unique case (state_q)
      ST_FETCH: begin
        mem_valid_o = 1'b1; mem_size_o = 2'd2;
        mem_addr_o  = fbase_q + {28'd0, idx_q, 2'b00};
      end
      ST_READ:  mem_valid_o = 1'b1;
      ST_WRITE: begin mem_valid_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = dst_q; end
      default: ;
    endcase
  end
  assign mem_wdata_o = buf_rd;

  assign run_o      = run_q;
  assign ev_start_o = ev_start_q;
  assign ev_end_o   = ev_end_q;
  assign ev_stop_o  = ev_stop_q;
  assign ev_eor_o   = ev_eor_q;
  assign cur_len_o  = len;
  assign cur_src_o  = src_q;
  assign cur_dst_o  = dst_q;

  // Assertions
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_o |-> !mem_valid_o);

  assert_hold_request_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_stop_drops_run_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ev_stop_o |-> !run_o);

  assert_flow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_ARB && flow && !periph_req_i && len != '0) |=> (state_q == ST_ARB));

  assert_eor_needs_flow_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    ev_eor_o |-> (cmd_q[CMD_FLOW_S] || cmd_q[CMD_FLOW_T]));
endmodule

// File: tb/chain_dma_engine_tb_top.sv
module chain_dma_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, nofetch, eor_stop, eor_jump, cmp, preq;
  logic [31:0] dptr, csrc, cdst, ccmd;
  logic        mvalid, mwe, mready, run, e_start, e_end, e_stop, e_eor;
  logic [31:0] maddr, mwdata, mrdata, csrc_o, cdst_o;
  logic [1:0]  msize;
  logic [12:0] clen;

  chain_dma_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_nofetch_i(nofetch),
    .cfg_desc_ptr_i(dptr), .cfg_src_i(csrc), .cfg_dst_i(cdst), .cfg_cmd_i(ccmd),
    .cfg_eor_stop_i(eor_stop), .cfg_eor_jump_i(eor_jump), .cmp_status_i(cmp),
    .periph_req_i(preq), .mem_valid_o(mvalid), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_size_o(msize), .mem_wdata_o(mwdata), .mem_ready_i(mready),
    .mem_rdata_i(mrdata), .run_o(run), .ev_start_o(e_start), .ev_end_o(e_end),
    .ev_stop_o(e_stop), .ev_eor_o(e_eor), .cur_len_o(clen), .cur_src_o(csrc_o),
    .cur_dst_o(cdst_o)
  );

  typedef struct { logic we; logic [31:0] addr; logic [1:0] size; logic [31:0] data; } acc_t;
  acc_t expq[$];
  logic [7:0] mem [4096];
  int n_run = 0, n_fail = 0, cyc = 0;
  int c_start, c_end, c_stop, c_eor;
  bit drop_on_write = 0, stall_prev = 0, we_prev;
  logic [31:0] addr_prev;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bmask(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // Monitor: memory model, scoreboard pop, event counters
  always @(negedge clk) begin
    cyc++;
    if (stall_prev)
      chk(mvalid && maddr == addr_prev && mwe == we_prev, "R12", "held request", maddr, addr_prev);
    mready = (cyc % 3) != 1;
    mrdata = {mem[maddr[11:0] + 12'd3], mem[maddr[11:0] + 12'd2],
              mem[maddr[11:0] + 12'd1], mem[maddr[11:0]]};
    if (rst_n && mvalid && mready) begin
      if (expq.size() == 0) chk(0, "R2/R6", "unexpected access", maddr, 32'h0);
      else begin
        acc_t e;
        e = expq.pop_front();
        chk(mwe == e.we && maddr == e.addr && msize == e.size, "R2/R6",
            "access addr", maddr, e.addr);
        if (mwe) begin
          chk((mwdata & bmask(msize)) == e.data, "R6", "write data", mwdata, e.data);
          for (int j = 0; j < (1 << msize); j++) mem[maddr[11:0] + 12'(j)] = mwdata[8*j +: 8];
          if (drop_on_write) begin preq = 1'b0; drop_on_write = 0; end
        end
      end
    end
    stall_prev = rst_n && mvalid && !mready;
    addr_prev = maddr; we_prev = mwe;
    if (rst_n) begin
      c_start += int'(e_start); c_end += int'(e_end);
      c_stop += int'(e_stop);   c_eor += int'(e_eor);
    end
  end

  task automatic put_word(input logic [31:0] a, input logic [31:0] w);
    for (int j = 0; j < 4; j++) mem[a[11:0] + 12'(j)] = w[8*j +: 8];
  endtask
  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, s, d, c);
    put_word(a, nx); put_word(a + 4, s); put_word(a + 8, d); put_word(a + 12, c);
  endtask
  task automatic exp_fetch(input logic [31:0] base);
    acc_t e;
    for (int k = 0; k < 4; k++) begin
      e.we = 0; e.addr = base + 32'(4 * k); e.size = 2'd2; e.data = 0;
      expq.push_back(e);
    end
  endtask
  // Expected accesses for a transfer, per the width/burst/increment rules (R6)
  task automatic exp_xfer(input logic [31:0] s0, d0, c, input int limit);
    acc_t e;
    logic [7:0] bb [36];
    int len, w, bs, si, di, done, b;
    logic [31:0] sa, da;
    logic [1:0] sz;
    len = int'(c[12:0]);
    w  = (c[15:14] == 2) ? 2 : (c[15:14] == 3) ? 4 : 1;
    sz = (w == 1) ? 2'd0 : (w == 2) ? 2'd1 : 2'd2;
    bs = 4 << c[17:16];
    si = c[31] ? w : 0; di = c[30] ? w : 0;
    sa = s0; da = d0; done = 0;
    while (len > 0 && done < limit) begin
      b = (len < bs) ? len : bs;
      for (int k = 0; k < b; k += w) begin
        e.we = 0; e.addr = sa; e.size = sz; e.data = 0; expq.push_back(e);
        for (int j = 0; j < w; j++) bb[k + j] = mem[sa[11:0] + 12'(j)];
        sa = sa + 32'(si);
      end
      for (int k = 0; k < b; k += w) begin
        e.we = 1; e.addr = da; e.size = sz; e.data = 0;
        for (int j = 0; j < w; j++) e.data[8*j +: 8] = bb[k + j];
        expq.push_back(e);
        da = da + 32'(di);
      end
      len -= b; done += b;
    end
  endtask

  task automatic go();
    c_start = 0; c_end = 0; c_stop = 0; c_eor = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && run; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] SI = 32'h8000_0000, DI = 32'h4000_0000;
  localparam logic [31:0] FS = 32'h2000_0000, FT = 32'h1000_0000;
  localparam logic [31:0] STE = 32'h0040_0000, ENE = 32'h0020_0000;

  initial begin
    logic [31:0] cA, cB;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 0; start = 0; nofetch = 0; eor_stop = 0; eor_jump = 0; cmp = 0; preq = 0;
    dptr = 0; csrc = 0; cdst = 0; ccmd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk(run == 0, "R1", "run after reset", 32'(run), 0);
    chk(mvalid == 0, "R1", "mem_valid after reset", 32'(mvalid), 0);
    chk({e_start, e_end, e_stop, e_eor} == 0, "R1", "events after reset",
        32'({e_start, e_end, e_stop, e_eor}), 0);

    // R2 R5 R6 R7 R8: aligned fetch, 4-byte elements, 8-byte bursts, 20 bytes
    cA = SI | DI | STE | ENE | (32'd1 << 16) | (32'd3 << 14) | 32'd20;
    put_desc(32'h100, 32'h1, 32'h400, 32'h800, cA);
    cmp = 1; dptr = 32'h10D;
    exp_fetch(32'h100); exp_xfer(32'h400, 32'h800, cA, 1000);
    go(); wait_idle();
    chk(expq.size() == 0, "R2", "pending accesses", 32'(expq.size()), 0);
    chk(c_start == 1, "R5", "start events", 32'(c_start), 1);
    chk(c_end == 1 && c_stop == 1, "R8", "end/stop events", 32'(c_end + c_stop), 2);
    chk(run == 0, "R8", "run after stop", 32'(run), 0);
    chk(clen == 0, "R7", "final length", 32'(clen), 0);
    chk(csrc_o == 32'h414 && cdst_o == 32'h814, "R6", "final src", csrc_o, 32'h414);

    // R3 R5 R6: branch to +32, 2-byte elements, fixed target
    cA = SI | ENE | (32'd2 << 16) | (32'd2 << 14) | 32'd6;
    put_desc(32'h200, 32'h1, 32'h600, 32'hA00, 32'h0);
    put_desc(32'h220, 32'h1, 32'h440, 32'h880, cA);
    cmp = 1; dptr = 32'h202;
    exp_fetch(32'h220); exp_xfer(32'h440, 32'h880, cA, 1000);
    go(); wait_idle();
    chk(expq.size() == 0, "R3", "branch fetch accesses", 32'(expq.size()), 0);
    chk(c_start == 0, "R5", "no start event", 32'(c_start), 0);
    chk(cdst_o == 32'h880, "R6", "fixed target", cdst_o, 32'h880);
    chk(csrc_o == 32'h446, "R6", "incremented source", csrc_o, 32'h446);

    // R8: chaining through a next pointer, 1-byte elements
    cA = SI | DI | ENE | (32'd1 << 14) | 32'd4;
    cB = SI | DI | ENE | (32'd1 << 14) | 32'd8;
    put_desc(32'h300, 32'h340, 32'h480, 32'h8C0, cA);
    put_desc(32'h340, 32'h1, 32'h4A0, 32'h8E0, cB);
    cmp = 0; dptr = 32'h300;
    exp_fetch(32'h300); exp_xfer(32'h480, 32'h8C0, cA, 1000);
    exp_fetch(32'h340); exp_xfer(32'h4A0, 32'h8E0, cB, 1000);
    go(); wait_idle();
    chk(expq.size() == 0, "R8", "chain accesses", 32'(expq.size()), 0);
    chk(c_end == 2 && c_stop == 1, "R8", "chain end events", 32'(c_end), 2);
    chk(csrc_o == 32'h4A8, "R8", "chain final src", csrc_o, 32'h4A8);

    // R11: direct mode, no descriptor reads
    cA = SI | DI | STE | (32'd3 << 14) | 32'd8;
    nofetch = 1; csrc = 32'h500; cdst = 32'h900; ccmd = cA;
    exp_xfer(32'h500, 32'h900, cA, 1000);
    go(); wait_idle();
    nofetch = 0;
    chk(expq.size() == 0, "R11", "direct accesses", 32'(expq.size()), 0);
    chk(c_stop == 1 && run == 0, "R11", "direct stop", 32'(c_stop), 1);
    chk(c_start == 0, "R11", "direct no start event", 32'(c_start), 0);
    chk(cdst_o == 32'h908, "R11", "direct final dst", cdst_o, 32'h908);

    // R4 R9 R10 R7: flow-controlled, end-of-receive stop
    cA = SI | DI | FS | FT | (32'd3 << 14) | 32'd16;
    put_desc(32'h380, 32'h1, 32'h523, 32'h942, cA);
    eor_stop = 1; preq = 0; dptr = 32'h380;
    exp_fetch(32'h380); exp_xfer(32'h520, 32'h940, cA, 4);
    go();
    repeat (30) @(negedge clk);
    chk(expq.size() == 2, "R9", "no burst without request", 32'(expq.size()), 2);
    chk(run == 1 && clen == 16, "R9", "length held", 32'(clen), 16);
    chk(csrc_o == 32'h520, "R4", "src low bits cleared", csrc_o, 32'h520);
    chk(cdst_o == 32'h940, "R4", "dst low bits cleared", cdst_o, 32'h940);
    drop_on_write = 1; preq = 1;
    wait_idle();
    chk(c_eor == 1 && c_stop == 1, "R10", "eor stop events", 32'(c_eor), 1);
    chk(clen == 12, "R7", "remaining after one burst", 32'(clen), 12);
    chk(run == 0 && expq.size() == 0, "R10", "stopped on eor", 32'(run), 0);

    // R10: end-of-receive jump to next descriptor
    cA = SI | DI | FS | (32'd3 << 14) | 32'd16;
    cB = SI | DI | (32'd3 << 14) | 32'd4;
    put_desc(32'h3C0, 32'h3E0, 32'h540, 32'h980, cA);
    put_desc(32'h3E0, 32'h1, 32'h560, 32'h9A0, cB);
    eor_stop = 0; eor_jump = 1; dptr = 32'h3C0;
    exp_fetch(32'h3C0); exp_xfer(32'h540, 32'h980, cA, 4);
    exp_fetch(32'h3E0); exp_xfer(32'h560, 32'h9A0, cB, 1000);
    drop_on_write = 1; preq = 1;
    go(); wait_idle();
    chk(expq.size() == 0, "R10", "jump accesses", 32'(expq.size()), 0);
    chk(c_eor == 1 && c_stop == 1, "R10", "jump events", 32'(c_eor + c_stop), 2);
    chk(csrc_o == 32'h564, "R10", "jump final src", csrc_o, 32'h564);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule